// File: doc/BRIEF.md
# Triggered Multi-Channel Capture Buffer

This block takes a synchronized snapshot of the traffic around a processing device so that it can be monitored. It has six capture memories, one for each 32-bit input link channel, and one capture memory for the 16-bit result stream. Every memory stays idle until the host writes a start command over a small register bus. From then on, each memory stores every word whose valid strobe is high until it holds its full depth. After that it freezes. The host can then read the snapshot at its own pace, one word per read access, from whichever memory it has selected.

Once recording is armed, a second start command has no effect. Only a clear command arms the buffer again. A clear empties every memory and also drops the sticky underflow flag. That flag is raised when the host reads a memory that has no unread words left.

Top module: `cap_snapshot`

## Requirements
- R1: After reset, a status read (address 0) returns zero, and a select read (address 1) returns zero.
- R2: A write to address 0 with bit 0 set and bit 1 clear arms all memories. From the cycle after that write, status bits 14:8 show every memory busy. Bit i of a status field stands for input memory i (0 to 5), and bit 6 stands for the output memory.
- R3: While a memory is busy, each cycle with its valid strobe high stores exactly one word, in arrival order. Cycles with the valid strobe low store nothing.
- R4: A memory that has stored its depth of words sets its full bit in status bits 6:0 and drops its busy bit. Later valid words are discarded, and the full bit stays set until a clear.
- R5: A start command issued while the buffer is armed is ignored. It resets no write position and changes no status.
- R6: A write to address 0 with bit 1 set empties all memories, disarms them and clears the underflow flag. In the same write, a clear takes precedence over a start.
- R7: A write to address 1 selects a memory by index in bits 2:0. Each read of address 2 returns the next unread word of the selected memory and advances by one word. Output words are zero-extended. A read returns its data on bus_rdata from the cycle after the read strobe.
- R8: A read of address 2 from an empty or non-existent memory returns zero, does not advance the memory, and sets status bit 16. That bit stays set until a clear.
- R9: Valid words that arrive while the buffer is not armed are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | Per-channel input word strobe |
| in_data | input | NUM_IN*IN_W | Input words, channel c in slice c*IN_W |
| out_valid | input | 1 | Result stream word strobe |
| out_data | input | OUT_W | Result stream word |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 command/status, 1 select, 2 data |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions check the following on every cycle: arming happens only after a start write, the armed state holds until a clear, full bits never drop without a clear, the underflow flag is sticky, and a clear empties all state. Only the bench scenarios can show the rest. These are the stored contents and their order under different valid patterns per channel, the rejection of words that arrive before arming, and the fact that a repeated start does not rewind a partially filled memory.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int BUS_DW = 32;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_SEL   = 2'd1,
        REG_DATA  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_CLEAR_BIT = 1;

    typedef struct packed {
        logic            wr;
        logic            rd;
        reg_addr_e       addr;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [14:0] rsvd;
        logic        uflow;
        logic [7:0]  busy;
        logic [7:0]  full;
    } status_t;

    function automatic logic [BUS_DW-1:0] pack_status(input logic [7:0] full,
                                                      input logic [7:0] busy,
                                                      input logic       uflow);
        status_t s;
        s.rsvd  = '0;
        s.uflow = uflow;
        s.busy  = busy;
        s.full  = full;
        return s;
    endfunction

endpackage

// File: rtl/cap_chan.sv
module cap_chan #(
    parameter int W     = 32,
    parameter int DEPTH = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         arm,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         rd_pop,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         busy,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] wr_cnt;
    logic [CW-1:0] rd_cnt;
    logic          wr_fire;

    assign full    = (wr_cnt == CW'(DEPTH));
    assign busy    = arm & ~full;
    assign empty   = (rd_cnt == wr_cnt);
    assign wr_fire = busy & wr_valid;
    assign rd_data = mem[rd_cnt[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (wr_fire)
                wr_cnt <= wr_cnt + CW'(1);
            if (rd_pop && !empty)
                rd_cnt <= rd_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire)
            mem[wr_cnt[AW-1:0]] <= wr_data;
    end

endmodule

// File: rtl/cap_host.sv
module cap_host
    import cap_pkg::*;
#(
    parameter int NUM_MEM = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  bus_req_t                       req,
    input  logic [NUM_MEM-1:0]             full_vec,
    input  logic [NUM_MEM-1:0]             busy_vec,
    input  logic [NUM_MEM-1:0]             empty_vec,
    input  logic [NUM_MEM-1:0][BUS_DW-1:0] word_vec,
    output logic                           armed,
    output logic                           clr,
    output logic [NUM_MEM-1:0]             pop_vec,
    output logic                           underflow,
    output logic [BUS_DW-1:0]              rdata
);
    localparam int SW = 3;

    logic [SW-1:0]     sel;
    logic              start;
    logic              data_rd;
    logic              sel_empty;
    logic [BUS_DW-1:0] sel_word;

    assign clr     = req.wr && (req.addr == REG_CTRL) && req.wdata[CMD_CLEAR_BIT];
    assign start   = req.wr && (req.addr == REG_CTRL) && req.wdata[CMD_START_BIT];
    assign data_rd = req.rd && (req.addr == REG_DATA);

    always_comb begin
        sel_word  = '0;
        sel_empty = 1'b1;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (sel == SW'(i)) begin
                sel_word  = word_vec[i];
                sel_empty = empty_vec[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_MEM; i++)
            pop_vec[i] = data_rd && (sel == SW'(i)) && !empty_vec[i];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            armed <= 1'b0;
        else if (start)
            armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel <= '0;
        else if (req.wr && req.addr == REG_SEL)
            sel <= req.wdata[SW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            underflow <= 1'b0;
        else if (data_rd && sel_empty)
            underflow <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            unique case (req.addr)
                REG_CTRL: rdata <= pack_status(8'(full_vec), 8'(busy_vec), underflow);
                REG_SEL:  rdata <= BUS_DW'(sel);
                REG_DATA: rdata <= sel_empty ? '0 : sel_word;
                default:  rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/cap_snapshot.sv
module cap_snapshot
    import cap_pkg::*;
#(
    parameter int NUM_IN    = 6,
    parameter int IN_W      = 32,
    parameter int IN_DEPTH  = 512,
    parameter int OUT_W     = 16,
    parameter int OUT_DEPTH = 512
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_IN-1:0]      in_valid,
    input  logic [NUM_IN*IN_W-1:0] in_data,
    input  logic                   out_valid,
    input  logic [OUT_W-1:0]       out_data,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [1:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata
);
    localparam int NUM_MEM = NUM_IN + 1;

    bus_req_t                       req;
    logic                           armed;
    logic                           clr;
    logic                           underflow;
    logic [NUM_MEM-1:0]             full_vec;
    logic [NUM_MEM-1:0]             busy_vec;
    logic [NUM_MEM-1:0]             empty_vec;
    logic [NUM_MEM-1:0]             pop_vec;
    logic [NUM_MEM-1:0][BUS_DW-1:0] word_vec;
    logic [OUT_W-1:0]               out_word;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.addr  = reg_addr_e'(bus_addr);
    assign req.wdata = bus_wdata;

    for (genvar c = 0; c < NUM_IN; c++) begin : g_in
        logic [IN_W-1:0] word;
        cap_chan #(.W(IN_W), .DEPTH(IN_DEPTH)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .clear    (clr),
            .arm      (armed),
            .wr_valid (in_valid[c]),
            .wr_data  (in_data[c*IN_W +: IN_W]),
            .rd_pop   (pop_vec[c]),
            .rd_data  (word),
            .full     (full_vec[c]),
            .busy     (busy_vec[c]),
            .empty    (empty_vec[c])
        );
        assign word_vec[c] = BUS_DW'(word);
    end

    cap_chan #(.W(OUT_W), .DEPTH(OUT_DEPTH)) u_out (
        .clk      (clk),
        .rst      (rst),
        .clear    (clr),
        .arm      (armed),
        .wr_valid (out_valid),
        .wr_data  (out_data),
        .rd_pop   (pop_vec[NUM_IN]),
        .rd_data  (out_word),
        .full     (full_vec[NUM_IN]),
        .busy     (busy_vec[NUM_IN]),
        .empty    (empty_vec[NUM_IN])
    );
    assign word_vec[NUM_IN] = BUS_DW'(out_word);

    cap_host #(.NUM_MEM(NUM_MEM)) u_host (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .full_vec  (full_vec),
        .busy_vec  (busy_vec),
        .empty_vec (empty_vec),
        .word_vec  (word_vec),
        .armed     (armed),
        .clr       (clr),
        .pop_vec   (pop_vec),
        .underflow (underflow),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/cap_snapshot_chk.sv
module cap_snapshot_chk #(
    parameter int NUM_MEM = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               armed,
    input logic               clr,
    input logic               underflow,
    input logic [NUM_MEM-1:0] full_vec
);
    // R2
    arm_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(bus_wr && bus_addr == 2'd0 && bus_wdata[0] && !bus_wdata[1]));

    // R5
    arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !clr) |=> armed);

    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (full_vec == '0 && !armed && !underflow));

    // R4
    full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((full_vec & $past(full_vec)) == $past(full_vec)));

    // R8
    uflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && !clr) |=> underflow);

endmodule

bind cap_snapshot cap_snapshot_chk #(.NUM_MEM(NUM_IN + 1)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .armed     (armed),
    .clr       (clr),
    .underflow (underflow),
    .full_vec  (full_vec)
);

// File: tb/tb_cap_snapshot.sv
module tb_cap_snapshot;
    localparam int NI    = 6;
    localparam int DEPTH = 8;
    localparam time CLK  = 8ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NI-1:0]   in_valid = '0;
    logic [NI*32-1:0] in_data = '0;
    logic            out_valid = 1'b0;
    logic [15:0]     out_data = '0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;

    int checks = 0;
    int errors = 0;
    int kin [NI];
    int kout = 0;
    int tick = 0;
    bit stream_on = 1'b0;
    logic [31:0] rd;

    always #(CLK/2) clk = ~clk;

    cap_snapshot #(.NUM_IN(NI), .IN_W(32), .IN_DEPTH(DEPTH),
                   .OUT_W(16), .OUT_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] in_word(input int c, input int k);
        return 32'hC000_0000 | (32'(c) << 16) | 32'(k);
    endfunction

    // stream generator: channel c valid every (c+1) ticks, output every other tick
    always @(negedge clk) begin
        for (int c = 0; c < NI; c++) begin
            if (stream_on && (tick % (c + 1)) == 0) begin
                in_valid[c] = 1'b1;
                in_data[c*32 +: 32] = in_word(c, kin[c]);
                kin[c]++;
            end else begin
                in_valid[c] = 1'b0;
            end
        end
        if (stream_on && tick[0] == 1'b0) begin
            out_valid = 1'b1;
            out_data  = 16'hA000 + 16'(kout);
            kout++;
        end else begin
            out_valid = 1'b0;
        end
        tick++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic stream(input int n);
        @(posedge clk); #1 stream_on = 1'b1;
        repeat (n) @(posedge clk);
        #1 stream_on = 1'b0;
        @(posedge clk);
    endtask

    task automatic zero_counts();
        for (int c = 0; c < NI; c++) kin[c] = 0;
        kout = 0;
    endtask

    // table: {kind (1=read check, 0=write), addr[1:0], data[31:0]}
    localparam int NT = 9;
    localparam logic [34:0] TBL [NT] = '{
        {1'b0, 2'd1, 32'd3},
        {1'b1, 2'd2, 32'hC003_0000},
        {1'b1, 2'd2, 32'hC003_0001},
        {1'b1, 2'd1, 32'd3},
        {1'b0, 2'd1, 32'd6},
        {1'b1, 2'd2, 32'h0000_A000},
        {1'b1, 2'd2, 32'h0000_A001},
        {1'b0, 2'd1, 32'd0},
        {1'b1, 2'd2, 32'hC000_0000}
    };

    initial begin
        #(CLK * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        zero_counts();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        bus_read(2'd0, rd); check("R1 status", rd, 32'h0);
        bus_read(2'd1, rd); check("R1 select", rd, 32'h0);

        // R9 words before start are dropped
        stream(20);
        bus_read(2'd0, rd); check("R9 status before start", rd, 32'h0);
        zero_counts();

        // R2 start arms all
        bus_write(2'd0, 32'h1);
        bus_read(2'd0, rd); check("R2 busy after start", rd, 32'h0000_7F00);

        // R4 fill everything
        stream(100);
        bus_read(2'd0, rd); check("R4 all full", rd, 32'h0000_007F);

        // R7 table walk
        for (int i = 0; i < NT; i++) begin
            if (TBL[i][34]) begin
                bus_read(TBL[i][33:32], rd);
                check("R7 table read", rd, TBL[i][31:0]);
            end else begin
                bus_write(TBL[i][33:32], TBL[i][31:0]);
            end
        end

        // R3 remaining words of channel 0 in order
        for (int k = 1; k < DEPTH; k++) begin
            bus_read(2'd2, rd); check("R3 ch0 order", rd, in_word(0, k));
        end
        // R3 sparse channel 5
        bus_write(2'd1, 32'd5);
        for (int k = 0; k < DEPTH; k++) begin
            bus_read(2'd2, rd); check("R3 ch5 order", rd, in_word(5, k));
        end
        // R4 output memory holds exactly DEPTH words
        bus_write(2'd1, 32'd6);
        for (int k = 2; k < DEPTH; k++) begin
            bus_read(2'd2, rd); check("R4 out word", rd, 32'hA000 + 32'(k));
        end

        // R8 empty read
        bus_read(2'd2, rd); check("R8 empty read zero", rd, 32'h0);
        bus_read(2'd0, rd); check("R8 underflow set", rd, 32'h0001_007F);
        bus_read(2'd2, rd); check("R8 still zero", rd, 32'h0);
        bus_read(2'd0, rd); check("R8 sticky", rd, 32'h0001_007F);

        // R5 start while armed changes nothing
        bus_write(2'd0, 32'h1);
        bus_read(2'd0, rd); check("R5 status unchanged", rd, 32'h0001_007F);

        // R6 clear
        bus_write(2'd0, 32'h2);
        zero_counts();
        bus_read(2'd0, rd); check("R6 status cleared", rd, 32'h0);
        bus_write(2'd1, 32'd1);
        bus_read(2'd2, rd); check("R6 memory emptied", rd, 32'h0);
        bus_write(2'd0, 32'h3);
        bus_read(2'd0, rd); check("R6 clear beats start", rd, 32'h0);

        // R5 partial capture, restart ignored
        bus_write(2'd0, 32'h1);
        stream(3);
        bus_read(2'd0, rd); check("R2 partial busy", rd, 32'h0000_7F00);
        bus_write(2'd0, 32'h1);
        stream(3);
        bus_write(2'd1, 32'd0);
        for (int k = 0; k < kin[0]; k++) begin
            bus_read(2'd2, rd); check("R5 ch0 not rewound", rd, in_word(0, k));
        end
        bus_read(2'd2, rd); check("R5 ch0 end", rd, 32'h0);
        bus_write(2'd1, 32'd1);
        for (int k = 0; k < kin[1]; k++) begin
            bus_read(2'd2, rd); check("R3 ch1 gaps", rd, in_word(1, k));
        end
        bus_read(2'd2, rd); check("R3 ch1 no extra", rd, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule